// File: doc/BRIEF.md
# Two-Wire Slave Port for a 16-Bit Register File

This block is a slave on a two-wire serial bus (clock line and open-drain data line). It lets an external bus master read and write a file of 16-bit registers that sit behind a plain internal register bus with 8-bit addresses. The bus lines are brought onto the system clock through synchronisers. The block detects start and stop conditions and matches one of four device addresses chosen by a two-bit strap. It captures a register pointer, and it moves whole 16-bit words with the high byte first. The pointer advances after every complete word.

A master writes by sending the device write address, a pointer byte, and then pairs of data bytes. Each pair becomes a single write strobe on the internal bus. A master reads by first setting the pointer with a write, then issuing a repeated start with the device read address. It acknowledges each returned byte and ends the read with a NACK.

One pointer value, 0xF0, is a staging address that allows byte-at-a-time access. An upper byte written on its own is kept in a staging register. A later byte written to 0xF0 completes that word and commits it. Likewise, the lower byte of the last word whose upper byte was read can be fetched through 0xF0. No half-word ever reaches the register file.

Top module: `twr_regport`

## Requirements
- R1: While reset is asserted and in the first cycle after it, sda_oe, wr_en and rd_req are all 0.
- R2: The strap addr_sel selects the 8-bit device address. Code 00 gives 0x90 for write and 0x91 for read, 01 gives 0x98/0x99, 10 gives 0xB0/0xB1, and 11 gives 0xB8/0xB9. The lowest bit is the direction bit, with 1 meaning read. Any other address is not acknowledged, and SDA then stays released until the next start condition.
- R3: In a write, the slave acknowledges the address byte, the pointer byte and every data byte by pulling SDA low for the ninth clock. sda_oe changes only while the synchronised SCL is low.
- R4: A write strobe occurs only once a data byte completes a 16-bit word. The strobe has wr_addr equal to the pointer and wr_data equal to {first byte, second byte}. A write may be ended by a stop or by a repeated start.
- R5: After each committed word at a normal address, the pointer increments by one, so the next byte pair goes to the next register.
- R6: After the read address is acknowledged, the slave returns the word at the pointer, high byte first. It advances to the next register after both bytes. A NACK (SDA high in the master's acknowledge bit) ends the read, and SDA stays released until the next start or stop. Read data is requested with a one-cycle rd_req pulse with the address on rd_addr, and rd_data must be valid one clock after that pulse.
- R7: When a data byte arrives at pointer 0xF0 as the first byte of a pair, the word {staged upper byte, this byte} is written to the address where the upper byte was staged.
- R8: A read started at pointer 0xF0 returns the lower byte of the word whose upper byte was most recently sent.
- R9: A single data byte followed by a stop, at a normal address, produces no write strobe. The target register keeps its old value.
- R10: wr_en is a one-cycle pulse and is never high in the same cycle as rd_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired-AND of all drivers) |
| addr_sel | input | 2 | Device address strap |
| sda_oe | output | 1 | When 1, pull SDA low |
| wr_en | output | 1 | Register write strobe, one cycle |
| wr_addr | output | 8 | Register write address |
| wr_data | output | 16 | Register write data |
| rd_req | output | 1 | Register read request, one cycle |
| rd_addr | output | 8 | Register read address |
| rd_data | input | 16 | Read data, valid one clock after rd_req |

## Verification
Several rules are checked on every cycle. sda_oe changes only while SCL is low. The line is released in the master's acknowledge slot and after an address mismatch. Write strobes are single-cycle, never coincide with read requests, and come only from byte reception. The reset values are also checked. The bench scenarios are needed for the rest: strap decoding, word assembly and address increment across several registers, suppression of a lone byte, and the two staging-address paths that link separate transactions through retained state. These can only be seen by driving whole bus transactions and comparing the register traffic and returned bytes against a model.

// File: rtl/twr_pkg.sv
package twr_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BYTE_W = 8;
    localparam int REG_AW = 8;
    localparam int REG_DW = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_WAIT
    } state_e;

    typedef enum logic [1:0] {
        K_DEV, K_REG, K_DATA
    } kind_e;

    typedef struct packed {
        state_e              st;
        kind_e               kind;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic                done;
        logic                is_rd;
        logic [REG_AW-1:0]   ptr;
        logic                half;
        logic [BYTE_W-1:0]   stg_hi;
        logic [REG_AW-1:0]   stg_addr;
        logic [BYTE_W-1:0]   rd_stage;
        logic [REG_DW-1:0]   word;
        logic                tx_lo;
        logic                nack;
        logic                oe;
        logic                wr_en;
        logic [REG_AW-1:0]   wr_addr;
        logic [REG_DW-1:0]   wr_data;
        logic                rd_req;
        logic                fetch;
    } core_t;

    // 7-bit device identity from the strap: base 0x90, strap bit 1 adds 0x20, bit 0 adds 0x08
    function automatic logic [6:0] dev_id(input logic [1:0] sel);
        logic [7:0] a;
        a = 8'h90 | {2'b00, sel[1], 1'b0, sel[0], 3'b000};
        return a[7:1];
    endfunction
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic lvl,
    output logic rise,
    output logic fall
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [STAGES-1:0] s_q, s_d;
    logic              prev_q, prev_d;

    always_comb begin
        s_d    = {s_q[STAGES-2:0], d};
        prev_d = s_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '1;
            prev_q <= 1'b1;
        end else begin
            s_q    <= s_d;
            prev_q <= prev_d;
        end
    end

    assign lvl  = s_q[STAGES-1];
    assign rise = s_q[STAGES-1] & ~prev_q;
    assign fall = ~s_q[STAGES-1] & prev_q;
endmodule

// File: rtl/twr_core.sv
module twr_core
    import twr_pkg::*;
#(
    parameter logic [REG_AW-1:0] STAGE_ADDR = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [6:0]        dev,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [REG_DW-1:0] wr_data,
    output logic              rd_req,
    output logic [REG_AW-1:0] rd_addr,
    input  logic [REG_DW-1:0] rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    core_t             q, n;
    logic [BYTE_W-1:0] tx;
    logic              start, stop;

    assign start = sda_fall & scl_lvl;
    assign stop  = sda_rise & scl_lvl;

    always_comb begin
        n        = q;
        tx       = '0;
        n.wr_en  = 1'b0;
        n.rd_req = 1'b0;
        n.fetch  = q.rd_req;
        if (q.fetch) n.word = rd_data;

        if (start) begin
            n.st   = ST_RX;
            n.kind = K_DEV;
            n.cnt  = '0;
            n.done = 1'b0;
            n.oe   = 1'b0;
        end else if (stop) begin
            n.st   = ST_IDLE;
            n.done = 1'b0;
            n.oe   = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        n.sh  = {q.sh[BYTE_W-2:0], sda_lvl};
                        n.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_LAST) n.done = 1'b1;
                    end else if (scl_fall && q.done) begin
                        n.done = 1'b0;
                        n.cnt  = '0;
                        n.st   = ST_ACK;
                        n.oe   = 1'b1;
                        case (q.kind)
                            K_DEV: begin
                                if (q.sh[BYTE_W-1:1] == dev) begin
                                    n.is_rd = q.sh[0];
                                    n.kind  = K_REG;
                                    if (q.sh[0] && q.ptr != STAGE_ADDR) n.rd_req = 1'b1;
                                end else begin
                                    n.st = ST_WAIT;
                                    n.oe = 1'b0;
                                end
                            end
                            K_REG: begin
                                n.ptr  = q.sh;
                                n.half = 1'b0;
                                n.kind = K_DATA;
                            end
                            default: begin
                                if (q.ptr == STAGE_ADDR) begin
                                    n.wr_en   = 1'b1;
                                    n.wr_addr = q.stg_addr;
                                    n.wr_data = {q.stg_hi, q.sh};
                                end else if (!q.half) begin
                                    n.stg_hi   = q.sh;
                                    n.stg_addr = q.ptr;
                                    n.half     = 1'b1;
                                end else begin
                                    n.wr_en   = 1'b1;
                                    n.wr_addr = q.ptr;
                                    n.wr_data = {q.stg_hi, q.sh};
                                    n.ptr     = q.ptr + 1'b1;
                                    n.half    = 1'b0;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (q.is_rd) begin
                            n.st  = ST_TX;
                            n.cnt = '0;
                            if (q.ptr == STAGE_ADDR) begin
                                tx = q.rd_stage;
                            end else begin
                                tx         = q.word[REG_DW-1:BYTE_W];
                                n.rd_stage = q.word[BYTE_W-1:0];
                                n.tx_lo    = 1'b0;
                            end
                            n.sh = tx;
                            n.oe = ~tx[BYTE_W-1];
                        end else begin
                            n.st = ST_RX;
                            n.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == CNT_LAST) begin
                            n.st = ST_MACK;
                            n.oe = 1'b0;
                        end else begin
                            n.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            n.cnt = q.cnt + 1'b1;
                            n.oe  = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        n.nack = sda_lvl;
                    end else if (scl_fall) begin
                        if (q.nack) begin
                            n.st = ST_WAIT;
                        end else begin
                            n.st  = ST_TX;
                            n.cnt = '0;
                            if (q.ptr == STAGE_ADDR) begin
                                tx = q.rd_stage;
                            end else if (!q.tx_lo) begin
                                tx       = q.word[BYTE_W-1:0];
                                n.tx_lo  = 1'b1;
                                n.ptr    = q.ptr + 1'b1;
                                n.rd_req = 1'b1;
                            end else begin
                                tx         = q.word[REG_DW-1:BYTE_W];
                                n.rd_stage = q.word[BYTE_W-1:0];
                                n.tx_lo    = 1'b0;
                            end
                            n.sh = tx;
                            n.oe = ~tx[BYTE_W-1];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sda_oe  = q.oe;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign rd_req  = q.rd_req;
    assign rd_addr = q.ptr;

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!q.oe && !q.wr_en && !q.rd_req));

    assert_quiet_mismatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT) |-> !q.oe);

    assert_oe_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> !scl_lvl);

    assert_commit_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> ($past(q.st) == ST_RX));

    assert_master_ack_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_MACK) |-> !q.oe);

    assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |=> !q.wr_en);

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.wr_en && q.rd_req));
endmodule

// File: rtl/twr_regport.sv
module twr_regport
    import twr_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [REG_AW-1:0] STAGE_ADDR  = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_sel,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [REG_DW-1:0] wr_data,
    output logic              rd_req,
    output logic [REG_AW-1:0] rd_addr,
    input  logic [REG_DW-1:0] rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LINES = 2;  // index 1: clock line, index 0: data line

    logic [LINES-1:0] raw, lvl, rise, fall;
    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        twr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw[g]),
            .lvl  (lvl[g]),
            .rise (rise[g]),
            .fall (fall[g])
        );
    end

    twr_core #(.STAGE_ADDR(STAGE_ADDR)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_lvl (lvl[1]),
        .scl_rise(rise[1]),
        .scl_fall(fall[1]),
        .sda_lvl (lvl[0]),
        .sda_rise(rise[0]),
        .sda_fall(fall[0]),
        .dev     (dev_id(addr_sel)),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: tb/twr_regport_tb.sv
module twr_regport_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int H = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_sel = 2'b11;
    logic        sda_oe, wr_en, rd_req;
    logic [7:0]  wr_addr, rd_addr;
    logic [15:0] wr_data;
    logic [15:0] rd_data = 16'h0000;
    logic        sda_line;

    int n_checks = 0;
    int n_err = 0;

    logic [23:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] mem [256];
    logic        wr_prev = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    twr_regport u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dev_of(input logic [1:0] s);
        case (s)
            2'b00:   return 8'h90;
            2'b01:   return 8'h98;
            2'b10:   return 8'hB0;
            default: return 8'hB8;
        endcase
    endfunction

    // register file model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = {i[7:0], ~i[7:0]};
        end else begin
            if (rd_req) rd_data <= mem[rd_addr];
            if (wr_en) begin
                chk("R10 single-cycle strobe", {31'd0, wr_prev}, 32'd0);
                chk("R10 no overlap", {31'd0, rd_req}, 32'd0);
                if (exp_q.size() == 0) begin
                    n_checks++;
                    n_err++;
                    $display("FAIL R9 unexpected write actual %h:%h expected none", wr_addr, wr_data);
                end else begin
                    chk(tag_q.pop_front(), {8'h00, wr_addr, wr_data}, {8'h00, exp_q.pop_front()});
                end
                mem[wr_addr] = wr_data;
            end
            wr_prev <= wr_en;
        end
    end

    task automatic expect_wr(input logic [7:0] a, input logic [15:0] d, input string tag);
        exp_q.push_back({a, d});
        tag_q.push_back(tag);
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        wt(H / 2);
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wt(H / 2);
        sda_m = 1'b0; wt(H / 2);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic put_bit(input logic b);
        wt(H / 2);
        sda_m = b; wt(H / 2);
        scl_m = 1'b1; wt(H);
        scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wt(H / 2);
        sda_m = 1'b1; wt(H / 2);
        scl_m = 1'b1; wt(H / 2);
        @(negedge clk) b = sda_line;
        wt(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic send(input logic [7:0] v, input logic exp_ack, input string req);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        chk(req, {31'd0, ~b}, {31'd0, exp_ack});
    endtask

    task automatic recv(input logic [7:0] expv, input logic nack, input string req);
        logic [7:0] v;
        logic       b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(nack);
        chk(req, {24'd0, v}, {24'd0, expv});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL R1 watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        wt(3);
        @(negedge clk);
        chk("R1 sda_oe in reset", {31'd0, sda_oe}, 32'd0);
        chk("R1 wr_en in reset", {31'd0, wr_en}, 32'd0);
        wt(5);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sda_oe after reset", {31'd0, sda_oe}, 32'd0);
        chk("R1 rd_req after reset", {31'd0, rd_req}, 32'd0);
        wt(H);

        // R3 R4: plain word write
        expect_wr(8'h09, 16'h0284, "R4 word commit");
        bus_start();
        send(8'hB8, 1'b1, "R3 ack device");
        send(8'h09, 1'b1, "R3 ack pointer");
        send(8'h02, 1'b1, "R3 ack high");
        send(8'h84, 1'b1, "R3 ack low");
        bus_stop();

        // R5: increment across three registers
        expect_wr(8'h20, 16'h1111, "R5 first word");
        expect_wr(8'h21, 16'h2222, "R5 second word");
        expect_wr(8'h22, 16'h3333, "R5 third word");
        bus_start();
        send(8'hB8, 1'b1, "R5 ack device");
        send(8'h20, 1'b1, "R5 ack pointer");
        send(8'h11, 1'b1, "R5 ack"); send(8'h11, 1'b1, "R5 ack");
        send(8'h22, 1'b1, "R5 ack"); send(8'h22, 1'b1, "R5 ack");
        send(8'h33, 1'b1, "R5 ack"); send(8'h33, 1'b1, "R5 ack");
        bus_stop();

        // R6: read with increment, NACK releases the line
        bus_start();
        send(8'hB8, 1'b1, "R6 ack device");
        send(8'h20, 1'b1, "R6 ack pointer");
        bus_start();
        send(8'hB9, 1'b1, "R6 ack read address");
        recv(8'h11, 1'b0, "R6 reg20 high");
        recv(8'h11, 1'b0, "R6 reg20 low");
        recv(8'h22, 1'b0, "R6 reg21 high");
        recv(8'h22, 1'b0, "R6 reg21 low");
        recv(8'h33, 1'b0, "R6 reg22 high");
        recv(8'h33, 1'b1, "R6 reg22 low");
        recv(8'hFF, 1'b1, "R6 released after NACK");
        bus_stop();

        // R9: lone byte is not committed
        bus_start();
        send(8'hB8, 1'b1, "R9 ack device");
        send(8'h30, 1'b1, "R9 ack pointer");
        send(8'hAB, 1'b1, "R9 ack lone byte");
        bus_stop();
        bus_start();
        send(8'hB8, 1'b1, "R9 ack device");
        send(8'h30, 1'b1, "R9 ack pointer");
        bus_start();
        send(8'hB9, 1'b1, "R9 ack read");
        recv(8'h30, 1'b0, "R9 reg30 high unchanged");
        recv(8'hCF, 1'b1, "R9 reg30 low unchanged");
        bus_stop();

        // R7: bytewise write through the staging address
        bus_start();
        send(8'hB8, 1'b1, "R7 ack device");
        send(8'h40, 1'b1, "R7 ack pointer");
        send(8'h12, 1'b1, "R7 ack upper");
        bus_stop();
        expect_wr(8'h40, 16'h1234, "R7 staged commit");
        bus_start();
        send(8'hB8, 1'b1, "R7 ack device");
        send(8'hF0, 1'b1, "R7 ack staging pointer");
        send(8'h34, 1'b1, "R7 ack lower");
        bus_stop();
        bus_start();
        send(8'hB8, 1'b1, "R7 ack device");
        send(8'h40, 1'b1, "R7 ack pointer");
        bus_start();
        send(8'hB9, 1'b1, "R7 ack read");
        recv(8'h12, 1'b0, "R7 reg40 high");
        recv(8'h34, 1'b1, "R7 reg40 low");
        bus_stop();

        // R8: bytewise read through the staging address
        bus_start();
        send(8'hB8, 1'b1, "R8 ack device");
        send(8'h09, 1'b1, "R8 ack pointer");
        bus_start();
        send(8'hB9, 1'b1, "R8 ack read");
        recv(8'h02, 1'b1, "R8 upper byte");
        bus_stop();
        bus_start();
        send(8'hB8, 1'b1, "R8 ack device");
        send(8'hF0, 1'b1, "R8 ack staging pointer");
        bus_start();
        send(8'hB9, 1'b1, "R8 ack read");
        recv(8'h84, 1'b1, "R8 lower byte via staging");
        bus_stop();

        // R4: write ended by a repeated start
        expect_wr(8'h50, 16'hAABB, "R4 word before repeated start");
        expect_wr(8'h51, 16'hCCDD, "R4 word after repeated start");
        bus_start();
        send(8'hB8, 1'b1, "R4 ack device");
        send(8'h50, 1'b1, "R4 ack pointer");
        send(8'hAA, 1'b1, "R4 ack"); send(8'hBB, 1'b1, "R4 ack");
        bus_start();
        send(8'hB8, 1'b1, "R4 ack device again");
        send(8'h51, 1'b1, "R4 ack pointer");
        send(8'hCC, 1'b1, "R4 ack"); send(8'hDD, 1'b1, "R4 ack");
        bus_stop();

        // R2: mismatch stays silent until a new start
        bus_start();
        send(8'hB0, 1'b0, "R2 no ack on mismatch");
        send(8'h00, 1'b0, "R2 still released");
        bus_start();
        send(8'hB8, 1'b1, "R2 ack after new start");
        send(8'h60, 1'b1, "R2 ack pointer");
        bus_stop();

        // R2: other strap codes
        for (int s = 0; s < 3; s++) begin
            addr_sel = 2'(s);
            wt(H);
            expect_wr(8'(8'h70 + s), {8'(s), 8'h55}, "R2 write via strap");
            bus_start();
            send(dev_of(2'(s)), 1'b1, "R2 ack strap write address");
            send(8'(8'h70 + s), 1'b1, "R2 ack pointer");
            send(8'(s), 1'b1, "R2 ack");
            send(8'h55, 1'b1, "R2 ack");
            bus_start();
            send(dev_of(2'(s)) | 8'h01, 1'b1, "R2 ack strap read address");
            recv(8'(8'h71 + s), 1'b1, "R2 read next register high");
            bus_stop();
        end
        addr_sel = 2'b00;
        wt(H);
        bus_start();
        send(8'hB8, 1'b0, "R2 no ack for other strap");
        bus_stop();

        wt(4 * H);
        chk("R4 all expected commits seen", exp_q.size(), 32'd0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule